// File: doc/BRIEF.md
# Serial Peripheral Master with Buffer Exception Policies

This block is a serial peripheral master. It moves words between a one-word transmit holding buffer and a one-word receive holding buffer. It drives the serial clock, the data-out line and one active-low chip select, and it samples the data-in line. Shifting uses SPI mode 0 with the most significant bit first. Each `start_i` pulse asks for one word. The host writes the transmit buffer, reads the receive buffer and watches the status flags.

The `mode_i` input picks how buffer exceptions are handled.

- **Host-paced mode (`mode_i`=0):** a requested word waits, with the serial clock idle, until the transmit buffer holds data and the receive buffer has been read.
- **Stream-paced mode (`mode_i`=1):** a requested word always runs.
  - If the transmit buffer is empty, the block shifts out zeros or repeats the last buffered word, according to `send_zero_i`.
  - If the receive buffer is still full at the end of a word, the block overwrites the held word or drops the new one, according to `get_more_i`.

In both modes, a sticky underflow flag or overflow flag marks the break in the data stream.

Top module: `spi_master_xfer`

## Requirements
- R1: After reset, `sclk_o`=0, `cs_no`=1, `tx_ready_o`=1, `rx_full_o`=0, `rx_data_o`=0, both sticky flags are 0, and the last-sent word is 0.
- R2: Each word is DATA_W bits, MSB first.
  - `cs_no` is low for the whole word.
  - `mosi_o` changes only while `sclk_o` falls or at load, and `miso_i` is sampled as `sclk_o` rises.
  - One `sclk_o` period is `div_i` system clocks (`div_i` even); values below 2 act as 2.
- R3: `tx_ready_o` is high while the transmit buffer is empty. It drops on `tx_wr_i` and rises once the word is taken for shifting. `rx_full_o` rises when a received word is stored and falls on `rx_rd_i`.
- R4: In stream-paced mode with the transmit buffer empty and `send_zero_i`=1, the word shifted out is all zeros and `tx_unf_o` is set.
- R5: In stream-paced mode with the transmit buffer empty and `send_zero_i`=0, the word shifted out is the last word taken from the transmit buffer, and `tx_unf_o` is set.
- R6: When a word completes with the receive buffer full and `get_more_i`=1, the new word replaces the held one and `rx_ovf_o` is set.
- R7: When a word completes with the receive buffer full and `get_more_i`=0, the new word is dropped, `rx_data_o` keeps the old word, and `rx_ovf_o` is set.
- R8: In host-paced mode, a start with the transmit buffer empty or the receive buffer full holds `sclk_o` low and `cs_no` high.
  - The start sets `tx_unf_o` (transmit buffer empty) or `rx_ovf_o` (receive buffer full).
  - The word runs once the buffers are serviced.
- R9: The sticky flags stay set until a pulse on `clr_tx_unf_i` or `clr_rx_ovf_i`. A set in the same cycle wins over the clear.
- R10: A `start_i` pulse while a word is pending or shifting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 host-paced, 1 stream-paced |
| send_zero_i | input | 1 | Empty transmit buffer policy: 1 send zeros, 0 resend last |
| get_more_i | input | 1 | Full receive buffer policy: 1 overwrite, 0 drop |
| div_i | input | DIV_W | Serial clock divider in system clocks (even) |
| start_i | input | 1 | Request one word transfer |
| tx_wr_i | input | 1 | Write transmit buffer |
| tx_data_i | input | DATA_W | Transmit word |
| rx_rd_i | input | 1 | Read receive buffer |
| rx_data_o | output | DATA_W | Receive buffer contents |
| tx_ready_o | output | 1 | Transmit buffer empty |
| rx_full_o | output | 1 | Receive buffer holds an unread word |
| tx_unf_o | output | 1 | Sticky transmit underflow |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| clr_tx_unf_i | input | 1 | Clear transmit underflow |
| clr_rx_ovf_i | input | 1 | Clear receive overflow |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
A wrong last-sent register or a wrong empty/full bit shows up on `mosi_o` or `rx_data_o` within one word time. The next word shifts out the wrong pattern, or the receive buffer holds the wrong word. A stall state that leaks shows up at once on `cs_no` and `sclk_o`, which must stay idle while a host-paced request waits. A sticky flag that is cleared or set wrongly is visible at the flag port in the cycle after the triggering start or word end.

// File: rtl/spi_ms_pkg.sv
package spi_ms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } ctl_state_e;

  localparam logic MODE_HOST   = 1'b0;
  localparam logic MODE_STREAM = 1'b1;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_w;

  // half period in system clocks, never below one
  assign half_w = (div_i < DIV_W'(2)) ? DIV_W'(1) : (div_i >> 1);
  assign tick_o = run_i && (cnt_q == half_w - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end

  assert_tick_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_word_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              active_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] txs_q, rxs_q;
  logic [CNT_W-1:0]  bit_q;
  logic              sclk_q, active_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txs_q    <= '0;
      rxs_q    <= '0;
      bit_q    <= '0;
      sclk_q   <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        txs_q    <= load_word_i;
        bit_q    <= '0;
        sclk_q   <= 1'b0;
        active_q <= 1'b1;
      end else if (active_q && tick_i) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rxs_q  <= {rxs_q[DATA_W-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            txs_q <= {txs_q[DATA_W-2:0], 1'b0};
            bit_q <= bit_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign active_o  = active_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = active_q & txs_q[DATA_W-1];
  assign done_o    = done_q;
  assign rx_word_o = rxs_q;

  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sclk_q);
  assert_mosi_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && $past(active_q) && $rose(sclk_q) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_master_xfer.sv
module spi_master_xfer
  import spi_ms_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              send_zero_i,
  input  logic              get_more_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_ready_o,
  output logic              rx_full_o,
  output logic              tx_unf_o,
  output logic              rx_ovf_o,
  input  logic              clr_tx_unf_i,
  input  logic              clr_rx_ovf_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  ctl_state_e        state_q, state_d;
  logic [DATA_W-1:0] tx_buf_q, rx_buf_q, last_tx_q, load_word, rx_word;
  logic              tx_full_q, rx_full_q, tuvf_q, rovf_q;
  logic              host_ready, go_ok, load, done, active, tick;
  logic              tuvf_set, rovf_set, rx_store;

  assign host_ready = tx_full_q && !rx_full_q;
  assign go_ok      = (mode_i == MODE_STREAM) || host_ready;
  assign load       = ((state_q == ST_IDLE) && start_i && go_ok) ||
                      ((state_q == ST_WAIT) && go_ok);

  // empty-buffer policy: zeros or repeat of last buffered word
  assign load_word = tx_full_q ? tx_buf_q : (send_zero_i ? '0 : last_tx_q);

  assign tuvf_set = (load && !tx_full_q) ||
                    ((state_q == ST_IDLE) && start_i && !go_ok && !tx_full_q);
  assign rovf_set = ((state_q == ST_IDLE) && start_i && !go_ok && rx_full_q) ||
                    (done && rx_full_q && !rx_rd_i);
  assign rx_store = done && (!rx_full_q || rx_rd_i || get_more_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load) state_d = ST_SHIFT; else if (start_i) state_d = ST_WAIT;
      ST_WAIT:  if (load) state_d = ST_SHIFT;
      ST_SHIFT: if (done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      last_tx_q <= '0;
      tuvf_q    <= 1'b0;
      rovf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tx_wr_i) begin
        tx_buf_q  <= tx_data_i;
        tx_full_q <= 1'b1;
      end else if (load) begin
        tx_full_q <= 1'b0;
      end
      if (load && tx_full_q) last_tx_q <= tx_buf_q;
      if (rx_store) begin
        rx_buf_q  <= rx_word;
        rx_full_q <= 1'b1;
      end else if (rx_rd_i) begin
        rx_full_q <= 1'b0;
      end
      tuvf_q <= tuvf_set | (tuvf_q & ~clr_tx_unf_i);
      rovf_q <= rovf_set | (rovf_q & ~clr_rx_ovf_i);
    end
  end

  spi_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (active),
    .div_i (div_i),
    .tick_o(tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_word_i(load_word),
    .tick_i     (tick),
    .miso_i     (miso_i),
    .active_o   (active),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .done_o     (done),
    .rx_word_o  (rx_word)
  );

  assign cs_no      = ~active;
  assign rx_data_o  = rx_buf_q;
  assign tx_ready_o = ~tx_full_q;
  assign rx_full_o  = rx_full_q;
  assign tx_unf_o   = tuvf_q;
  assign rx_ovf_o   = rovf_q;

  assert_host_stall_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> cs_no && !sclk_o);
  assert_drop_keeps_rx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && rx_full_q && !rx_rd_i && !get_more_i |=> $stable(rx_buf_q));
  assert_overwrite_rx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && rx_full_q && get_more_i |=> rx_buf_q == $past(rx_word));
  assert_tuvf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tuvf_q && !clr_tx_unf_i |=> tuvf_q);
  assert_rovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rovf_q && !clr_rx_ovf_i |=> rovf_q);
  assert_one_word_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SHIFT && !done |=> state_q == ST_SHIFT);
endmodule

// File: tb/test_spi_master_xfer.sv
`timescale 1ns/1ps
module test_spi_master_xfer;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       mode = 1'b1, sz = 1'b0, gm = 1'b0, start = 1'b0;
  logic [7:0] div = 8'd4;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, clr_t = 1'b0, clr_r = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic       tx_ready, rx_full, tuvf, rovf, sclk, mosi, miso, cs_n;
  int         n_run = 0, n_fail = 0, words = 0, bidx = 8;
  logic [7:0] cap = '0, slv_next = '0;
  bit         done_flag = 0;

  always #2 clk = ~clk;

  spi_master_xfer i_spi_master_xfer (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .send_zero_i(sz), .get_more_i(gm),
    .div_i(div), .start_i(start), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .tx_ready_o(tx_ready), .rx_full_o(rx_full),
    .tx_unf_o(tuvf), .rx_ovf_o(rovf), .clr_tx_unf_i(clr_t), .clr_rx_ovf_i(clr_r),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n));

  // slave model: MSB first, next bit after each falling edge
  assign miso = (bidx < 8) ? slv_next[7 - bidx] : 1'b0;
  always @(posedge sclk) cap <= {cap[6:0], mosi};
  initial forever begin
    @(negedge cs_n);
    words++;
    bidx = 0;
    while (!cs_n) begin
      @(negedge sclk or posedge cs_n);
      if (!cs_n) bidx++;
    end
    bidx = 8;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; cyc(1); start = 1'b0;
  endtask
  task automatic pulse_rd();
    rx_rd = 1'b1; cyc(1); rx_rd = 1'b0;
  endtask
  task automatic pulse_clr();
    clr_t = 1'b1; clr_r = 1'b1; cyc(1); clr_t = 1'b0; clr_r = 1'b0;
  endtask
  task automatic write_tx(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; cyc(1); tx_wr = 1'b0;
  endtask

  typedef struct packed {
    logic       wr;
    logic [7:0] txd;
    logic       rd;
    logic       sz;
    logic       gm;
    logic [7:0] slv;
    logic [7:0] e_mosi;
    logic [7:0] e_rx;
    logic       e_tuvf;
    logic       e_rovf;
  } vec_t;

  // stream-paced sequence, state carries over between rows
  localparam vec_t VECS [0:6] = '{
    '{1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hA5, 8'h3C, 1'b0, 1'b0}, // R2
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h11, 8'h00, 8'h11, 1'b1, 1'b0}, // R4
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h22, 8'hA5, 8'h22, 1'b1, 1'b0}, // R5
    '{1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 8'h33, 8'h5A, 8'h22, 1'b0, 1'b1}, // R7
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h44, 8'h5A, 8'h44, 1'b1, 1'b1}, // R6 R5
    '{1'b1, 8'hC3, 1'b1, 1'b1, 1'b0, 8'h81, 8'hC3, 8'h81, 1'b0, 1'b0}, // R2
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b1}  // R4 R6
  };

  initial begin
    #1000000;
    if (!done_flag) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    time t1, t2;
    int w0;
    cyc(3);
    chk("R1 sclk", sclk, 0);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 flags", {tuvf, rovf}, 0);
    rst_ni = 1'b1;
    cyc(2);

    // R5: last-sent word is zero after reset
    mode = 1'b1; sz = 1'b0; slv_next = 8'h00;
    pulse_start(); cyc(40);
    chk("R5 reset last word", cap, 8'h00);
    pulse_rd(); pulse_clr();

    // R3: transmit status
    write_tx(8'hA5);
    chk("R3 tx_ready after write", tx_ready, 0);
    pulse_rd(); pulse_clr();
    for (int i = 0; i < 7; i++) begin
      if (i != 0) begin
        if (VECS[i].rd) pulse_rd();
        pulse_clr();
        if (VECS[i].wr) write_tx(VECS[i].txd);
      end
      sz = VECS[i].sz; gm = VECS[i].gm; slv_next = VECS[i].slv;
      pulse_start(); cyc(3);
      if (i == 0) chk("R3 tx_ready after load", tx_ready, 1);
      if (i == 0) chk("R2 cs_n low in word", cs_n, 0);
      cyc(37);
      chk($sformatf("vec%0d R2/R4/R5 mosi", i), cap, VECS[i].e_mosi);
      chk($sformatf("vec%0d R6/R7 rx_data", i), rx_data, VECS[i].e_rx);
      chk($sformatf("vec%0d R4/R5 tuvf", i), tuvf, VECS[i].e_tuvf);
      chk($sformatf("vec%0d R6/R7 rovf", i), rovf, VECS[i].e_rovf);
      chk($sformatf("vec%0d R3 rx_full", i), rx_full, 1);
    end

    // R9: sticky until cleared
    cyc(5);
    chk("R9 flags held", {tuvf, rovf}, 2'b11);
    pulse_rd();
    chk("R3 rx_full cleared by read", rx_full, 0);
    pulse_clr();
    chk("R9 flags cleared", {tuvf, rovf}, 2'b00);

    // R8: host-paced stall on empty transmit buffer
    mode = 1'b0; slv_next = 8'h5C;
    pulse_start(); cyc(10);
    chk("R8 stall cs_n", cs_n, 1);
    chk("R8 stall sclk", sclk, 0);
    chk("R8 tuvf on stall", tuvf, 1);
    chk("R8 rovf no stall", rovf, 0);
    write_tx(8'h96); cyc(40);
    chk("R8 resumed mosi", cap, 8'h96);
    chk("R8 resumed rx", rx_data, 8'h5C);

    // R8: host-paced stall on full receive buffer
    pulse_clr();
    write_tx(8'h69);
    pulse_start(); cyc(10);
    chk("R8 stall rx full cs_n", cs_n, 1);
    chk("R8 rovf on stall", rovf, 1);
    chk("R8 tuvf clear", tuvf, 0);
    chk("R8 tx still held", tx_ready, 0);
    slv_next = 8'h0F;
    pulse_rd(); cyc(40);
    chk("R8 after read mosi", cap, 8'h69);
    chk("R8 after read rx", rx_data, 8'h0F);

    // R10: start while shifting is ignored
    pulse_rd(); pulse_clr();
    write_tx(8'h11);
    w0 = words;
    pulse_start(); cyc(8);
    pulse_start(); cyc(80);
    chk("R10 single word", words - w0, 1);
    chk("R10 no stall flag", {tuvf, rovf}, 2'b00);
    chk("R10 cs idle", cs_n, 1);

    // R2: divider periods
    pulse_rd();
    mode = 1'b1; div = 8'd6;
    pulse_start();
    @(posedge sclk); t1 = $time;
    @(posedge sclk); t2 = $time;
    chk("R2 period div6", 32'(t2 - t1), 24);
    cyc(60); pulse_rd();
    div = 8'd0;
    pulse_start();
    @(posedge sclk); t1 = $time;
    @(posedge sclk); t2 = $time;
    chk("R2 period div0 as 2", 32'(t2 - t1), 8);
    cyc(30);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule